// File: doc/BRIEF.md
# Byte-Serial Stack Pointer and Context Sequencer

This block holds the stack pointer of a small 8-bit processor and moves context between the core and a byte-wide stack memory one byte per clock. The pointer's upper byte is hard-wired to a fixed page, so the stack covers a single 256-byte window and wraps silently at both ends. Pushing a byte, popping a byte, subroutine call and return, and interrupt entry and return all run through one sequencer that drives address, write data, write enable and read enable. The same sequencer captures read data from a memory with one cycle of read latency.

The core issues a command with `cmd_valid` and an opcode. It presents the program counter and the registers alongside the command, and it collects restored values when `done` pulses. Resetting the pointer to the top of the page and loading its low byte are single-cycle commands. The low byte is always visible on `sp_low`.

Top module: `bstk_engine`

## Requirements
- R1: Every memory access uses an address whose upper byte is the page constant (default 01h), so all accesses fall in 0100h..01FFh.
- R2: After reset, and one cycle after an accepted reset-pointer command (opcode 7), `sp_low` is FFh.
- R3: A push (opcode 1, data on `cmd_byte`) writes at the address the pointer holds and then decrements it. A pop (opcode 2) increments the pointer first and then reads, and the byte appears on `pop_byte` when `done` pulses.
- R4: Decrement from 00h gives FFh and increment from FFh gives 00h, with no flag and no other effect.
- R5: A load command (opcode 8) sets `sp_low` to `cmd_byte` one cycle later. The page byte is unchanged.
- R6: A call (opcode 3) writes the PC low byte at the pointer and the PC high byte one address below it, leaving the pointer two lower.
- R7: A return (opcode 4) reads the PC high byte and then the PC low byte, and presents the 16-bit address on `ret_pc` with `done`.
- R8: Interrupt entry (opcode 5) writes PC low, PC high, X, A and CC at five successively lower addresses, starting at the pointer.
- R9: Interrupt return (opcode 6) reads CC, A, X, PC high and PC low in that order, and presents them on `cc_out`, `a_out`, `x_out` and `ret_pc` with `done`.
- R10: One byte moves per clock. `busy` is high for N cycles for an N-byte save and for N+1 cycles for an N-byte restore. `done` pulses for one cycle, while `busy` is low, right after the operation; for opcodes 7 and 8 this is the cycle after acceptance.
- R11: A command presented while `busy` is high has no effect on the pointer or on memory, and no access occurs while idle.
- R12: Context saved by interrupt entry and restored by interrupt return comes back unchanged, even when the five bytes straddle the page wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 4 | Command opcode |
| cmd_byte | input | 8 | Push data or pointer load value |
| pc_in | input | 16 | Program counter to save |
| cc_in | input | 8 | Condition codes to save |
| a_in | input | 8 | Accumulator to save |
| x_in | input | 8 | Index register to save |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| mem_re | output | 1 | Stack memory read enable |
| mem_rdata | input | 8 | Stack memory read data, one cycle after `mem_re` |
| sp_low | output | 8 | Low byte of the stack pointer |
| ret_pc | output | 16 | Restored program counter |
| cc_out | output | 8 | Restored condition codes |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored index register |
| pop_byte | output | 8 | Byte returned by a single pop |

## Verification
The hardest case to reach is a multi-byte save or restore that crosses the page boundary. A second hard case is a command that arrives partway through such a sequence. The stimulus loads the pointer low byte to 02h or 01h before an interrupt entry or a call, so that the bytes wrap from 0100h to 01FFh, and then restores them in reverse. During the first busy cycle of the interrupt entry the bench presents a pointer load of 00h. Any acceptance of that load would shift every later address and show up in the scoreboard's pointer and data checks.

// File: rtl/bstk_pkg.sv
package bstk_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_CALL = 4'd3,
    OP_RET  = 4'd4,
    OP_INT  = 4'd5,
    OP_IRET = 4'd6,
    OP_RSP  = 4'd7,
    OP_LDSP = 4'd8
  } op_e;

  localparam int unsigned MAX_BEATS = 5;
  localparam int unsigned IDX_W     = $clog2(MAX_BEATS + 1);

  function automatic logic is_save(op_e op);
    return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_INT);
  endfunction

  function automatic logic is_restore(op_e op);
    return (op == OP_POP) || (op == OP_RET) || (op == OP_IRET);
  endfunction

  function automatic logic is_single(op_e op);
    return (op == OP_RSP) || (op == OP_LDSP);
  endfunction

  function automatic logic [IDX_W-1:0] beat_count(op_e op);
    case (op)
      OP_PUSH, OP_POP: return IDX_W'(1);
      OP_CALL, OP_RET: return IDX_W'(2);
      OP_INT, OP_IRET: return IDX_W'(5);
      default:         return '0;
    endcase
  endfunction
endpackage

// File: rtl/bstk_ptr.sv
module bstk_ptr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_top,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] sp_lo
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] sp_q, sp_d;
  logic         sp_en;

  always_comb begin
    sp_en = set_top | load | dec | inc;
    sp_d  = sp_q;
    if (set_top)   sp_d = '1;
    else if (load) sp_d = load_val;
    else if (dec)  sp_d = sp_q - ONE;
    else if (inc)  sp_d = sp_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '1;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_lo = sp_q;
endmodule

// File: rtl/bstk_seq.sv
module bstk_seq
  import bstk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  output logic             accept,
  output op_e              op_q,
  output logic             save_beat,
  output logic             rest_beat,
  output logic [IDX_W-1:0] beat_idx,
  output logic             cap_v,
  output logic [IDX_W-1:0] cap_idx,
  output logic             set_top,
  output logic             load_lo,
  output logic             busy,
  output logic             done
);
  op_e              cmd_e, op_d;
  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d, cnt_q, cnt_d;
  logic             capv_q, capv_d, caplast_q, caplast_d;
  logic [IDX_W-1:0] capidx_q, capidx_d;
  logic             done_q, done_d;
  logic             last_beat, cmd_known, seq_en;

  always_comb begin
    cmd_e     = op_e'(cmd_op);
    cmd_known = is_save(cmd_e) || is_restore(cmd_e) || is_single(cmd_e);
    busy      = act_q | capv_q;
    accept    = cmd_valid & ~busy & cmd_known;
    set_top   = accept & (cmd_e == OP_RSP);
    load_lo   = accept & (cmd_e == OP_LDSP);
    last_beat = act_q & (idx_q == IDX_W'(cnt_q - IDX_W'(1)));
    save_beat = act_q & is_save(op_q);
    rest_beat = act_q & is_restore(op_q);

    act_d = act_q;
    op_d  = op_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (accept && !is_single(cmd_e)) begin
      act_d = 1'b1;
      op_d  = cmd_e;
      idx_d = '0;
      cnt_d = beat_count(cmd_e);
    end else if (act_q) begin
      idx_d = idx_q + IDX_W'(1);
      if (last_beat) act_d = 1'b0;
    end
    seq_en = accept | act_q;

    capv_d    = rest_beat;
    capidx_d  = idx_q;
    caplast_d = rest_beat & last_beat;
    done_d    = (accept & is_single(cmd_e))
              | (save_beat & last_beat)
              | (capv_q & caplast_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      op_q  <= OP_NOP;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (seq_en) begin
      act_q <= act_d;
      op_q  <= op_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capv_q    <= 1'b0;
      capidx_q  <= '0;
      caplast_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      capv_q    <= capv_d;
      capidx_q  <= capidx_d;
      caplast_q <= caplast_d;
      done_q    <= done_d;
    end
  end

  assign beat_idx = idx_q;
  assign cap_v    = capv_q;
  assign cap_idx  = capidx_q;
  assign done     = done_q;
endmodule

// File: rtl/bstk_ctx.sv
module bstk_ctx
  import bstk_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [3:0]       cmd_op,
  input  logic [W-1:0]     cmd_byte,
  input  logic [2*W-1:0]   pc_in,
  input  logic [W-1:0]     cc_in,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     x_in,
  input  op_e              op_q,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic             cap_v,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [W-1:0]     mem_rdata,
  output logic [W-1:0]     wdata,
  output logic [2*W-1:0]   ret_pc,
  output logic [W-1:0]     cc_out,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     x_out,
  output logic [W-1:0]     pop_byte
);
  // slot map: 0 PC low, 1 PC high, 2 X, 3 A, 4 CC
  logic [W-1:0]     snap_in [MAX_BEATS];
  logic [W-1:0]     snap_q  [MAX_BEATS];
  logic [W-1:0]     res_q   [MAX_BEATS];
  logic             snap_en;
  logic [IDX_W-1:0] cap_slot;
  logic             pop_en;
  logic [W-1:0]     pop_q;

  always_comb begin
    snap_en    = accept & is_save(op_e'(cmd_op));
    snap_in[0] = (op_e'(cmd_op) == OP_PUSH) ? cmd_byte : pc_in[W-1:0];
    snap_in[1] = pc_in[2*W-1:W];
    snap_in[2] = x_in;
    snap_in[3] = a_in;
    snap_in[4] = cc_in;
    if (op_q == OP_IRET) cap_slot = IDX_W'(4) - cap_idx;
    else                 cap_slot = IDX_W'(1) - cap_idx;
    pop_en = cap_v & (op_q == OP_POP);
  end

  always_comb begin
    wdata = '0;
    for (int i = 0; i < MAX_BEATS; i++)
      if (beat_idx == IDX_W'(i)) wdata = snap_q[i];
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
    logic res_en;
    assign res_en = cap_v & ((op_q == OP_RET) | (op_q == OP_IRET))
                  & (cap_slot == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q[g] <= '0;
      else if (snap_en) snap_q[g] <= snap_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q[g] <= '0;
      else if (res_en) res_q[g] <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pop_q <= '0;
    else if (pop_en) pop_q <= mem_rdata;
  end

  assign ret_pc   = {res_q[1], res_q[0]};
  assign x_out    = res_q[2];
  assign a_out    = res_q[3];
  assign cc_out   = res_q[4];
  assign pop_byte = pop_q;
endmodule

// File: rtl/bstk_engine.sv
module bstk_engine
  import bstk_pkg::*;
#(
  parameter int unsigned     DATA_W = 8,
  parameter logic [DATA_W-1:0] PAGE = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [3:0]          cmd_op,
  input  logic [DATA_W-1:0]   cmd_byte,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   cc_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   x_in,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   sp_low,
  output logic [2*DATA_W-1:0] ret_pc,
  output logic [DATA_W-1:0]   cc_out,
  output logic [DATA_W-1:0]   a_out,
  output logic [DATA_W-1:0]   x_out,
  output logic [DATA_W-1:0]   pop_byte
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             accept, save_beat, rest_beat, cap_v, set_top, load_lo;
  op_e              op_q;
  logic [IDX_W-1:0] beat_idx, cap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  bstk_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .accept(accept), .op_q(op_q), .save_beat(save_beat), .rest_beat(rest_beat),
    .beat_idx(beat_idx), .cap_v(cap_v), .cap_idx(cap_idx),
    .set_top(set_top), .load_lo(load_lo), .busy(busy), .done(done)
  );

  bstk_ptr #(.W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .set_top(set_top), .load(load_lo),
    .load_val(cmd_byte), .dec(save_beat), .inc(rest_beat), .sp_lo(sp_low)
  );

  bstk_ctx #(.W(DATA_W)) u_ctx (
    .clk(clk), .rst_n(rst_sync_n), .accept(accept), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .pc_in(pc_in), .cc_in(cc_in), .a_in(a_in), .x_in(x_in),
    .op_q(op_q), .beat_idx(beat_idx), .cap_v(cap_v), .cap_idx(cap_idx),
    .mem_rdata(mem_rdata), .wdata(mem_wdata), .ret_pc(ret_pc), .cc_out(cc_out),
    .a_out(a_out), .x_out(x_out), .pop_byte(pop_byte)
  );

  always_comb begin
    mem_we   = save_beat;
    mem_re   = rest_beat;
    mem_addr = rest_beat ? {PAGE, DATA_W'(sp_low + DATA_W'(1))} : {PAGE, sp_low};
  end
endmodule

// File: rtl/bstk_checker.sv
module bstk_checker #(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] PAGE   = 8'h01
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [3:0]          cmd_op,
  input logic [DATA_W-1:0]   cmd_byte,
  input logic                busy,
  input logic                done,
  input logic                mem_we,
  input logic                mem_re,
  input logic [2*DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0]   sp_low
);
  p_page_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[2*DATA_W-1:DATA_W] == PAGE);

  p_rsp_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 4'd7) |=> sp_low == '1);

  p_push_at_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[DATA_W-1:0] == sp_low);

  p_pop_above_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> mem_addr[DATA_W-1:0] == DATA_W'(sp_low + DATA_W'(1)));

  p_push_wrap_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_low == DATA_W'($past(sp_low) - DATA_W'(1)));

  p_pop_wrap_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp_low == DATA_W'($past(sp_low) + DATA_W'(1)));

  p_load_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 4'd8) |=> sp_low == $past(cmd_byte));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we && !mem_re) |=> $stable(sp_low));
endmodule

bind bstk_engine bstk_checker #(.DATA_W(DATA_W), .PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_byte(cmd_byte), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .sp_low(sp_low)
);

// File: tb/bstk_engine_test.sv
module bstk_engine_test;
  localparam logic [3:0] PUSH = 4'd1, POP = 4'd2, CALL = 4'd3, RET = 4'd4,
                         INTR = 4'd5, IRET = 4'd6, RSP = 4'd7, LDSP = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [7:0]  cmd_byte, cc_in, a_in, x_in, mem_wdata, mem_rdata, sp_low;
  logic [7:0]  cc_out, a_out, x_out, pop_byte;
  logic [15:0] pc_in, mem_addr, ret_pc;
  logic        busy, done, mem_we, mem_re;

  int n_chk = 0, n_fail = 0, page_bad = 0;

  typedef struct {
    logic [3:0]  op;
    logic [15:0] pc;
    logic [7:0]  cc, a, x, pb, spl;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_sp;

  always #5 clk = ~clk;

  bstk_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .pc_in(pc_in), .cc_in(cc_in), .a_in(a_in), .x_in(x_in),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .sp_low(sp_low),
    .ret_pc(ret_pc), .cc_out(cc_out), .a_out(a_out), .x_out(x_out),
    .pop_byte(pop_byte)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compare each done pulse against the oldest expected item
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re) && mem_addr[15:8] != 8'h01) page_bad++;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(sp_low == e.spl, e.tag, "sp_low", {24'd0, sp_low}, {24'd0, e.spl});
        if (e.op == POP)
          chk(pop_byte == e.pb, "R3", "pop_byte", {24'd0, pop_byte}, {24'd0, e.pb});
        if (e.op == RET)
          chk(ret_pc == e.pc, "R7", "ret_pc", {16'd0, ret_pc}, {16'd0, e.pc});
        if (e.op == IRET) begin
          chk(ret_pc == e.pc, "R9", "ret_pc", {16'd0, ret_pc}, {16'd0, e.pc});
          chk(cc_out == e.cc, "R9", "cc_out", {24'd0, cc_out}, {24'd0, e.cc});
          chk(a_out == e.a, "R12", "a_out", {24'd0, a_out}, {24'd0, e.a});
          chk(x_out == e.x, "R12", "x_out", {24'd0, x_out}, {24'd0, e.x});
        end
      end
    end
  end

  // driver: build expectation, issue command, check timing and memory image
  task automatic do_op(input logic [3:0] op, input logic [7:0] b, input logic [15:0] pc,
                       input logic [7:0] cc, input logic [7:0] a, input logic [7:0] x,
                       input bit poke, input string tag);
    exp_t e;
    logic [7:0] bytes [5];
    logic [7:0] sp0;
    int n = 0, exp_busy = 0, bcnt = 0;
    sp0 = ref_sp;
    e.op = op; e.pc = '0; e.cc = '0; e.a = '0; e.x = '0; e.pb = '0; e.tag = tag;
    for (int i = 0; i < 5; i++) bytes[i] = '0;
    case (op)
      PUSH: begin n = 1; bytes[0] = b; end
      CALL: begin n = 2; bytes[0] = pc[7:0]; bytes[1] = pc[15:8]; end
      INTR: begin n = 5; bytes[0] = pc[7:0]; bytes[1] = pc[15:8];
                  bytes[2] = x; bytes[3] = a; bytes[4] = cc; end
      POP:  begin n = 1; e.pb = ref_mem[8'(sp0 + 8'd1)]; end
      RET:  begin n = 2; e.pc = {ref_mem[8'(sp0 + 8'd1)], ref_mem[8'(sp0 + 8'd2)]}; end
      IRET: begin n = 5;
                  e.cc = ref_mem[8'(sp0 + 8'd1)]; e.a = ref_mem[8'(sp0 + 8'd2)];
                  e.x  = ref_mem[8'(sp0 + 8'd3)];
                  e.pc = {ref_mem[8'(sp0 + 8'd4)], ref_mem[8'(sp0 + 8'd5)]}; end
      RSP:  ref_sp = 8'hFF;
      LDSP: ref_sp = b;
      default: ;
    endcase
    if (op == PUSH || op == CALL || op == INTR) begin
      for (int k = 0; k < n; k++) ref_mem[8'(sp0 - 8'(k))] = bytes[k];
      ref_sp = 8'(sp0 - 8'(n));
      exp_busy = n;
    end else if (op == POP || op == RET || op == IRET) begin
      ref_sp = 8'(sp0 + 8'(n));
      exp_busy = n + 1;
    end
    e.spl = ref_sp;
    exp_q.push_back(e);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; pc_in = pc; cc_in = cc; a_in = a; x_in = x;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      // R11: a load presented during a busy sequence must be ignored
      cmd_valid = 1'b1; cmd_op = LDSP; cmd_byte = 8'h00;
    end
    while (busy) begin
      bcnt++;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    chk(bcnt == exp_busy, "R10", "busy cycles", bcnt, exp_busy);
    chk(done == 1'b1, "R10", "done after op", {31'd0, done}, 32'd1);
    if (op == PUSH || op == CALL || op == INTR)
      for (int k = 0; k < n; k++)
        chk(mem[8'(sp0 - 8'(k))] == bytes[k], tag, "stored byte",
            {24'd0, mem[8'(sp0 - 8'(k))]}, {24'd0, bytes[k]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_byte = '0;
    pc_in = '0; cc_in = '0; a_in = '0; x_in = '0;
    ref_sp = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk(sp_low == 8'hFF, "R2", "reset sp_low", {24'd0, sp_low}, 32'hFF);
    chk(!busy && !done && !mem_we && !mem_re, "R2", "reset idle",
        {28'd0, busy, done, mem_we, mem_re}, 32'd0);

    do_op(PUSH, 8'hA5, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R3");
    do_op(POP,  8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R3");
    do_op(LDSP, 8'h02, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R5");
    // R8/R4/R11: five bytes from 0102h down across the wrap to 01FEh, with a poke
    do_op(INTR, 8'h00, 16'h1234, 8'h0A, 8'h55, 8'h66, 1'b1, "R8");
    do_op(IRET, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R12");
    do_op(CALL, 8'h00, 16'hBEEF, 8'h0, 8'h0, 8'h0, 1'b0, "R6");
    do_op(RET,  8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R7");
    // R4: call from 01h wraps the pointer to FFh; return wraps it back
    do_op(LDSP, 8'h01, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R5");
    do_op(CALL, 8'h00, 16'hC0DE, 8'h0, 8'h0, 8'h0, 1'b0, "R6");
    do_op(RET,  8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R4");
    // R4: pop at FFh reads 0100h
    do_op(LDSP, 8'hFF, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R5");
    do_op(POP,  8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R4");
    do_op(LDSP, 8'h40, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R5");
    do_op(RSP,  8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R2");
    // second interrupt round trip from the top of the page
    do_op(INTR, 8'h00, 16'h8001, 8'hC3, 8'h00, 8'hFF, 1'b1, "R8");
    do_op(IRET, 8'h00, 16'h0, 8'h0, 8'h0, 8'h0, 1'b0, "R9");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "pending results", exp_q.size(), 32'd0);
    chk(page_bad == 0, "R1", "accesses outside page", page_bad, 32'd0);
    finish_run();
  end
endmodule